// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a supervisory timer. Software turns it on through a small control register, selects one of four timeout lengths, and must then keep proving that it is alive. It does this by writing a fixed two-byte unlock pair to a service register. If the pair does not arrive before the selected number of timer ticks has gone by, the block asks the system to reset. The request is a pulse of fixed length, and the block raises a sticky overflow flag. That flag survives the system reset the pulse causes, so software can tell after the restart why it happened.

Ticks come from an external prescaler as a single-cycle enable. Every system reset turns the watchdog off, including the reset it triggered itself. Software has to enable it again after each one. Only a power-on reset clears everything, the flag included.

Top module: `wdt_keyed`

## Requirements
- R1: After the power-on reset (`rst_n` low) `rst_req` is 0 and `ctrl_rd` reads 0x00. A power-on reset also clears a set overflow flag.
- R2: A write with `wr_addr`=0 loads the control register. Bit 0 is enable, bits 2:1 are the timeout select, and bit 7 is the overflow flag. `ctrl_rd` returns these three fields in the same positions, and the other bits read 0.
- R3: While enabled, the block times out on the N-th counted tick, where N = 2^(14+2*select). `rst_req` rises in the cycle after the clock edge that takes that tick. Cycles without a tick do not count. While disabled, no number of ticks raises `rst_req`.
- R4: A timeout drives `rst_req` high for exactly 16 consecutive clock cycles.
- R5: A timeout sets the overflow flag and clears the enable bit. Both changes are visible from the first cycle of the pulse.
- R6: The overflow flag is unchanged by `sys_rst`. A control write with bit 7 = 0 clears it. A control write with bit 7 = 1 leaves it as it was.
- R7: `sys_rst` (synchronous, active high) clears the enable bit, the timeout select, the tick count and the key detector.
- R8: A write of 0x1E to the service register (`wr_addr`=1), followed directly by a write of 0xE1 as the next register write, restarts the count from zero.
- R9: Any register write between 0x1E and 0xE1 cancels the sequence, and the following 0xE1 has no effect on the count. This covers a service write of any other value and any control write.
- R10: Clearing the enable bit clears the count. After re-enabling, a full timeout period of ticks is needed.
- R11: When the completing 0xE1 write and a tick fall in the same cycle as the terminal tick, the restart wins. No timeout occurs and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sys_rst | input | 1 | Synchronous active-high system reset (any source) |
| tick | input | 1 | Prescaler enable, one counted tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = service register |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | Reset request pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| ctrl_rd | output | 8 | Control register read value |

## Verification
The bench lands the restart write on the very tick that would expire the count. A design that let the timeout win there would fire a reset that the service was meant to prevent. It breaks the unlock pair with an intervening random service value and, separately, with an intervening control write. A detector that stayed armed would accept the late 0xE1 and never time out at the expected tick. It feeds the request pulse back as the system reset and then reads the flag. A flag wired to the system reset would read 0 there, and an enable that survived would keep counting. It also disables and re-enables the watchdog mid-count, which exposes a counter that only pauses instead of clearing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int TSEL_W   = 2;
    localparam int EN_BIT   = 0;
    localparam int TSEL_LSB = 1;
    localparam int OVF_BIT  = 7;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic              en;
        logic [TSEL_W-1:0] tsel;
        logic              ovf;
    } ctrl_t;

endpackage

// File: rtl/wdt_key_detect.sv
module wdt_key_detect
    import wdt_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_LAST  = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  logic              svc_wr,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] data,
    output logic              restart
);

    typedef struct packed {
        key_state_e st;
    } key_reg_t;

    key_reg_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        restart = 1'b0;
        if (sys_rst) begin
            s_d.st = KEY_IDLE;
        end else begin
            case (s_q.st)
                KEY_IDLE: begin
                    if (svc_wr && data == KEY_FIRST) s_d.st = KEY_ARMED;
                end
                KEY_ARMED: begin
                    if (svc_wr && data == KEY_LAST) begin
                        s_d.st  = KEY_IDLE;
                        restart = 1'b1;
                    end else if (svc_wr || ctl_wr) begin
                        s_d.st = KEY_IDLE;
                    end
                end
                default: s_d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: KEY_IDLE};
        else        s_q <= s_d;
    end

    AST_KEY_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart); // R8

    AST_KEY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !svc_wr) |=> !restart); // R9

endmodule

// File: rtl/wdt_timeout_counter.sv
module wdt_timeout_counter
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int STEP_LOG2 = 2,
    parameter int CNT_W     = BASE_LOG2 + STEP_LOG2 * ((1 << TSEL_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic              tick,
    input  logic              restart,
    input  logic [TSEL_W-1:0] tsel,
    output logic              timeout
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t    s_d, s_q;
    logic [CNT_W:0] term_m1;
    int unsigned    shift;

    always_comb begin
        shift   = BASE_LOG2 + STEP_LOG2 * int'(tsel);
        term_m1 = ((CNT_W+1)'(1) << shift) - (CNT_W+1)'(1);
        timeout = en && tick && !restart && !clear && ({1'b0, s_q.cnt} >= term_m1);
        s_d     = s_q;
        if (!en || clear || restart || timeout) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && tick && !restart && !timeout) |=> s_q.cnt == $past(s_q.cnt) + 1'b1); // R3

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || clear || restart) |=> s_q.cnt == '0); // R10

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
    parameter int PULSE_LEN = 16,
    localparam int PW       = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_req
);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_reg_t;

    pulse_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fire) begin
            s_d.left = PW'(PULSE_LEN);
        end else if (s_q.left != '0) begin
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rst_req = (s_q.left != '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rst_req); // R4

    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |=> rst_req); // R4

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                BASE_LOG2 = 14,
    parameter int                STEP_LOG2 = 2,
    parameter int                PULSE_LEN = 16,
    parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_LAST  = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_req,
    output logic              ovf_flag,
    output logic [DATA_W-1:0] ctrl_rd
);

    localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * ((1 << TSEL_W) - 1);

    ctrl_t c_d, c_q;
    logic  wr_ctl, wr_svc, restart, timeout;

    assign wr_ctl = wr_en && (wr_addr == 1'b0);
    assign wr_svc = wr_en && (wr_addr == 1'b1);

    wdt_key_detect #(
        .DATA_W   (DATA_W),
        .KEY_FIRST(KEY_FIRST),
        .KEY_LAST (KEY_LAST)
    ) i_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .sys_rst(sys_rst),
        .svc_wr (wr_svc),
        .ctl_wr (wr_ctl),
        .data   (wr_data),
        .restart(restart)
    );

    wdt_timeout_counter #(
        .BASE_LOG2(BASE_LOG2),
        .STEP_LOG2(STEP_LOG2),
        .CNT_W    (CNT_W)
    ) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sys_rst),
        .en     (c_q.en),
        .tick   (tick),
        .restart(restart),
        .tsel   (c_q.tsel),
        .timeout(timeout)
    );

    wdt_pulse_gen #(
        .PULSE_LEN(PULSE_LEN)
    ) i_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (timeout),
        .rst_req(rst_req)
    );

    always_comb begin
        c_d = c_q;
        if (sys_rst) begin
            c_d.en   = 1'b0;
            c_d.tsel = '0;
        end else if (wr_ctl) begin
            c_d.en   = wr_data[EN_BIT];
            c_d.tsel = wr_data[TSEL_LSB +: TSEL_W];
            c_d.ovf  = c_q.ovf & wr_data[OVF_BIT];
        end
        if (timeout) begin
            c_d.en  = 1'b0;
            c_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        ctrl_rd                       = '0;
        ctrl_rd[EN_BIT]               = c_q.en;
        ctrl_rd[TSEL_LSB +: TSEL_W]   = c_q.tsel;
        ctrl_rd[OVF_BIT]              = c_q.ovf;
    end

    assign ovf_flag = c_q.ovf;

    AST_FIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> c_q.en); // R3

    AST_OVF_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (c_q.ovf && !c_q.en)); // R5

    AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && c_q.ovf) |=> c_q.ovf); // R6

    AST_SYS_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !c_q.en); // R7

endmodule

// File: tb/test_wdt_keyed.sv
`timescale 1ns/1ps
module test_wdt_keyed;

    logic       clk = 1'b0;
    logic       rst_n, sys_rst, tick, wr_en, wr_addr;
    logic [7:0] wr_data;
    logic       rst_req, ovf_flag;
    logic [7:0] ctrl_rd;
    logic       force_sys = 1'b0;
    int         checks = 0;
    int         errors = 0;

    localparam int TERM0 = 1 << 14;

    always #4 clk = ~clk;

    wdt_keyed i_wdt_keyed (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rst_req(rst_req), .ovf_flag(ovf_flag), .ctrl_rd(ctrl_rd)
    );

    function automatic logic [7:0] ctrl_val(input logic en, input logic [1:0] ts, input logic ov);
        return {ov, 4'b0, ts, en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic we, input logic a, input logic [7:0] d);
        @(negedge clk);
        tick    = t;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        sys_rst = rst_req | force_sys;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b0, d);
    endtask

    task automatic wr_svc(input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b1, d);
    endtask

    task automatic ticks_quiet(input int n, input string tag);
        logic bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 8'h00);
            if (rst_req) bad = 1'b1;
        end
        check(tag, bad, 1'b0);
    endtask

    task automatic wait_pulse(output int len);
        len = 1;
        idle();
        while (rst_req && len < 100) begin
            len++;
            idle();
        end
        idle();
    endtask

    task automatic expect_fire(input string tag);
        int len;
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check(tag, rst_req, 1'b1);
        wait_pulse(len);
    endtask

    initial begin
        repeat (198000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int  n, len;
        logic bad;
        logic t;
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; sys_rst = 1'b0; tick = 1'b0;
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rst_req", rst_req, 1'b0);
        check("R1 reset ctrl", ctrl_rd, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        wr_ctl(8'h05);
        check("R2 readback en+sel2", ctrl_rd, ctrl_val(1'b1, 2'd2, 1'b0));
        wr_ctl(8'h7B);
        check("R2 unused bits read 0", ctrl_rd, ctrl_val(1'b1, 2'd1, 1'b0));
        wr_ctl(8'h01);

        // R3 random tick gaps, R4 pulse length, R5 flag/enable
        n = 0; bad = 1'b0;
        while (n < TERM0 - 1) begin
            t = (($urandom % 4) != 0);
            cyc(t, 1'b0, 1'b0, 8'h00);
            if (t) n++;
            if (rst_req) bad = 1'b1;
        end
        check("R3 no reset before terminal tick", bad, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check("R3 reset on terminal tick", rst_req, 1'b1);
        check("R5 flag set and disabled", ctrl_rd, ctrl_val(1'b0, 2'd0, 1'b1));
        wait_pulse(len);
        check("R4 pulse length", len, 16);
        check("R6 flag survives system reset", ctrl_rd, ctrl_val(1'b0, 2'd0, 1'b1));
        check("R6 flag output", ovf_flag, 1'b1);

        ticks_quiet(TERM0 + 600, "R3 disabled never resets");

        wr_ctl(8'h81);
        check("R6 write bit7=1 keeps flag", ctrl_rd, ctrl_val(1'b1, 2'd0, 1'b1));
        wr_ctl(8'h01);
        check("R6 write bit7=0 clears flag", ctrl_rd, ctrl_val(1'b1, 2'd0, 1'b0));

        // R7
        wr_ctl(8'h05);
        ticks_quiet(300, "R7 pre");
        force_sys = 1'b1; idle(); force_sys = 1'b0;
        check("R7 system reset clears control", ctrl_rd, 8'h00);
        wr_ctl(8'h01);
        ticks_quiet(TERM0 - 1, "R7 count cleared by system reset");
        expect_fire("R7 full period after system reset");

        // R8
        wr_ctl(8'h01);
        ticks_quiet(5000, "R8 pre");
        wr_svc(8'h1E); wr_svc(8'hE1);
        ticks_quiet(TERM0 - 1, "R8 key restarted count");
        expect_fire("R8 timeout after restart");

        // R9 random intervening service value
        wr_ctl(8'h01);
        ticks_quiet(10000, "R9 pre");
        v = 8'($urandom);
        if (v == 8'hE1) v = 8'h00;
        wr_svc(8'h1E); wr_svc(v); wr_svc(8'hE1);
        ticks_quiet(TERM0 - 10000 - 1, "R9 broken key quiet");
        expect_fire("R9 broken by service value");

        // R9 intervening control write
        wr_ctl(8'h01);
        ticks_quiet(10000, "R9 pre2");
        wr_svc(8'h1E); wr_ctl(8'h01); wr_svc(8'hE1);
        ticks_quiet(TERM0 - 10000 - 1, "R9 broken key quiet2");
        expect_fire("R9 broken by control write");

        // R10
        wr_ctl(8'h01);
        ticks_quiet(10000, "R10 pre");
        wr_ctl(8'h00); wr_ctl(8'h01);
        ticks_quiet(TERM0 - 1, "R10 disable cleared count");
        expect_fire("R10 full period after re-enable");

        // R11
        wr_ctl(8'h01);
        ticks_quiet(TERM0 - 1, "R11 pre");
        wr_svc(8'h1E);
        cyc(1'b1, 1'b1, 1'b1, 8'hE1);
        check("R11 restart beats terminal tick", rst_req, 1'b0);
        ticks_quiet(TERM0 - 1, "R11 quiet after restart");
        expect_fire("R11 timeout after restart");

        check("R1 flag set before power-on", ovf_flag, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        #2;
        check("R1 power-on clears flag", ctrl_rd, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule